// File: doc/BRIEF.md
# Parallel Bus Write-Cycle Capture

This block sits behind the pins of an x8 parallel memory port. It samples the asynchronous chip-select, write-strobe and output-enable lines (all active low) with a fast local clock. It turns them into clean single-clock write events for a downstream command decoder. Each event carries the address and the data byte that the bus cycle presented. All three strobes, the address bus and the data bus pass through the same two-flop synchronizer, so the captured values stay aligned with the strobes.

A write exists only while chip-select and write-strobe are both low. Their overlap is called the combined strobe. The address is taken when the combined strobe opens, which is when the later of the two lines goes low. The data is the last value seen while the combined strobe is still open, which is the value present when the earlier of the two lines goes high. Two rules reject a write. The first is a minimum-width filter, counted in sampling clocks. The second is an inhibit: if output-enable is low at any point during the strobe, the write is dropped.

On the read side, the block raises a pad drive enable and forwards the array's read byte only while chip-select and output-enable are both low. It also gives a one-clock pulse at the start of each read window.

Top module: `strobe_capture`

## Requirements
- R1: A write event (`wr_valid` high for exactly one clock) is produced once per combined strobe, after that strobe ends, and only if the strobe passes both rejection rules.
- R2: `wr_addr` of an event equals the synchronized address seen in the first sampling clock of the combined strobe. Address changes made later in the strobe are ignored. This holds whichever of chip-select or write-strobe falls last.
- R3: `wr_data` of an event equals the synchronized data seen in the last sampling clock of the combined strobe. Data present earlier in the strobe, and data changed together with the first rising line, are not used.
- R4: A combined strobe that is active for fewer than `MIN_PULSE` sampling clocks produces no event. One that is active for `MIN_PULSE` or more clocks produces exactly one event.
- R5: If output-enable is low in any sampling clock of the combined strobe, the strobe produces no event.
- R6: Write-strobe pulses while chip-select is high produce no event.
- R7: `dq_oe` is 1 and `dq_out` equals `rd_data` only while chip-select and output-enable are both low, after synchronization. At all other times `dq_oe` is 0 and `dq_out` is all zeros.
- R8: `rd_start` pulses for one clock, in the clock where `dq_oe` rises, once per read window.
- R9: While reset is low, and after it is released with idle strobes, `wr_valid`, `wr_addr`, `wr_data`, `dq_oe`, `dq_out` and `rd_start` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip-select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr_in | input | ADDR_W | Address bus |
| dq_in | input | DATA_W | Data bus as driven by the host |
| rd_data | input | DATA_W | Byte from the array for the current read |
| wr_valid | output | 1 | One-clock write event |
| wr_addr | output | ADDR_W | Address of the last write event |
| wr_data | output | DATA_W | Data byte of the last write event |
| rd_start | output | 1 | One-clock pulse at the opening of a read window |
| dq_oe | output | 1 | Data pad drive enable |
| dq_out | output | DATA_W | Data to drive onto the pad |

## Verification
Writes are issued with chip-select falling first and with write-strobe falling first, and with each line rising first. Each combination tells whether the address is taken at the later falling edge and the data at the earlier rising edge. During every strobe the bench changes the address after its first clock and changes the data mid-strobe, so a capture at the wrong moment returns a value the bench can detect. Strobe widths just below, at and above the minimum separate a filter that is off by one from a correct one. Strobes with an output-enable blip, and write-strobe pulses with chip-select high, show that the inhibit rules drop those writes without producing an event.

// File: rtl/strobe_capture_pkg.sv
package strobe_capture_pkg;

  // Overlap of the two active-low write qualifiers.
  function automatic logic comb_strobe(input logic ce_n, input logic we_n);
    return (ce_n == 1'b0) && (we_n == 1'b0);
  endfunction

  // Read window: chip-select and output-enable both low.
  function automatic logic read_window(input logic ce_n, input logic oe_n);
    return (ce_n == 1'b0) && (oe_n == 1'b0);
  endfunction

  // A finished strobe qualifies when it was wide enough and never inhibited.
  function automatic logic pulse_qualifies(input int unsigned width,
                                           input int unsigned min_width,
                                           input logic inhibited);
    return (width >= min_width) && !inhibited;
  endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= {WIDTH{RST_VAL}};
      end else if (s == 0) begin
        stage_q[s] <= d;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/write_qualifier.sv
module write_qualifier
  import strobe_capture_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MIN_PULSE = 4,
  localparam int unsigned CNT_W    = $clog2(MIN_PULSE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_s,
  input  logic              we_n_s,
  input  logic              oe_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              strobe_act,
  output logic              strobe_start,
  output logic              strobe_end,
  output logic              inhibit_q,
  output logic [CNT_W-1:0]  width_cnt,
  output logic [ADDR_W-1:0] addr_hold
);

  logic              strobe_q;
  logic [DATA_W-1:0] data_hold;
  logic [CNT_W-1:0]  cnt_next;
  logic              qualifies;

  assign strobe_act   = comb_strobe(ce_n_s, we_n_s);
  assign strobe_start = strobe_act && !strobe_q;
  assign strobe_end   = !strobe_act && strobe_q;
  assign cnt_next     = (width_cnt >= CNT_W'(MIN_PULSE)) ? width_cnt
                                                         : width_cnt + CNT_W'(1);
  assign qualifies    = pulse_qualifies(32'(width_cnt), MIN_PULSE, inhibit_q);

  // Track the open strobe: address at its first clock, data at every clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      width_cnt <= '0;
      inhibit_q <= 1'b0;
      addr_hold <= '0;
      data_hold <= '0;
    end else begin
      strobe_q <= strobe_act;
      if (strobe_start) begin
        width_cnt <= CNT_W'(1);
        inhibit_q <= !oe_n_s;
        addr_hold <= addr_s;
        data_hold <= data_s;
      end else if (strobe_act) begin
        width_cnt <= cnt_next;
        data_hold <= data_s;
        if (!oe_n_s) begin
          inhibit_q <= 1'b1;
        end
      end
    end
  end

  // Emit the event one clock after the strobe closes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= strobe_end && qualifies;
      if (strobe_end && qualifies) begin
        wr_addr <= addr_hold;
        wr_data <= data_hold;
      end
    end
  end

endmodule

// File: rtl/read_gate.sv
module read_gate
  import strobe_capture_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_s,
  input  logic              oe_n_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_start,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);

  logic window;

  assign window = read_window(ce_n_s, oe_n_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe    <= 1'b0;
      rd_start <= 1'b0;
    end else begin
      dq_oe    <= window;
      rd_start <= window && !dq_oe;
    end
  end

  assign dq_out = dq_oe ? rd_data : '0;

endmodule

// File: rtl/strobe_capture.sv
module strobe_capture
  import strobe_capture_pkg::*;
#(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MIN_PULSE   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(MIN_PULSE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_start,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);

  // Synchronized strobes (reset to the inactive level) and buses.
  logic [2:0]        strb_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  // Internal events brought out for the checker.
  logic              strobe_act;
  logic              strobe_start;
  logic              strobe_end;
  logic              inhibit_q;
  logic [CNT_W-1:0]  width_cnt;
  logic [ADDR_W-1:0] addr_hold;

  bus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d({oe_n, we_n, ce_n}), .q(strb_s)
  );

  bus_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_addr_sync (
    .clk(clk), .rst_n(rst_n), .d(addr_in), .q(addr_s)
  );

  bus_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(dq_in), .q(data_s)
  );

  write_qualifier #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_wq (
    .clk(clk), .rst_n(rst_n),
    .ce_n_s(strb_s[0]), .we_n_s(strb_s[1]), .oe_n_s(strb_s[2]),
    .addr_s(addr_s), .data_s(data_s),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .strobe_act(strobe_act), .strobe_start(strobe_start), .strobe_end(strobe_end),
    .inhibit_q(inhibit_q), .width_cnt(width_cnt), .addr_hold(addr_hold)
  );

  read_gate #(.DATA_W(DATA_W)) u_rg (
    .clk(clk), .rst_n(rst_n),
    .ce_n_s(strb_s[0]), .oe_n_s(strb_s[2]),
    .rd_data(rd_data),
    .rd_start(rd_start), .dq_oe(dq_oe), .dq_out(dq_out)
  );

endmodule

// File: rtl/strobe_capture_chk.sv
module strobe_capture_chk #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MIN_PULSE = 4,
  localparam int unsigned CNT_W    = $clog2(MIN_PULSE + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input logic              rd_start,
  input logic              strobe_act,
  input logic              strobe_start,
  input logic              strobe_end,
  input logic              inhibit_q,
  input logic [CNT_W-1:0]  width_cnt,
  input logic [ADDR_W-1:0] addr_hold
);

  p_event_after_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(strobe_end));

  p_single_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  p_addr_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_act && !strobe_start) |=> $stable(addr_hold));

  p_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(width_cnt) >= CNT_W'(MIN_PULSE)));

  p_oe_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(inhibit_q));

  p_pad_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  p_read_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> (dq_oe && !$past(dq_oe)));

endmodule

bind strobe_capture strobe_capture_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .dq_oe(dq_oe), .dq_out(dq_out),
  .rd_start(rd_start), .strobe_act(strobe_act), .strobe_start(strobe_start),
  .strobe_end(strobe_end), .inhibit_q(inhibit_q), .width_cnt(width_cnt),
  .addr_hold(addr_hold)
);

// File: tb/strobe_capture_tb.sv
module strobe_capture_tb;

  localparam int unsigned AW  = 19;
  localparam int unsigned DW  = 8;
  localparam int unsigned MINW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] rd_data = '0;
  logic          wr_valid, rd_start, dq_oe;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, dq_out;

  int checks = 0;
  int fails  = 0;
  int rd_pulses = 0;
  logic [AW+DW-1:0] exp_q [$];

  always #5 clk = ~clk;

  strobe_capture #(.ADDR_W(AW), .DATA_W(DW), .MIN_PULSE(MINW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr_in(addr_in), .dq_in(dq_in), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_start(rd_start), .dq_oe(dq_oe), .dq_out(dq_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every event.
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected write event, addr", 32'(wr_addr), 32'h0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        check(wr_addr == e[AW+DW-1:DW], "R2", "event address", 32'(wr_addr), 32'(e[AW+DW-1:DW]));
        check(wr_data == e[DW-1:0], "R3", "event data", 32'(wr_data), 32'(e[DW-1:0]));
      end
    end
    if (rst_n && rd_start) rd_pulses++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one bus write; pushes the expected item when it should qualify.
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int width, input bit we_first, input bit ce_rises_first,
                           input bit oe_blip, input bit expect_ev, input string req);
    addr_in = a ^ AW'(1);
    dq_in   = ~d;
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    idle(2);
    addr_in = a;
    if (expect_ev) exp_q.push_back({a, d});
    if (we_first) ce_n = 1'b0; else we_n = 1'b0;
    if (width == 1) dq_in = d;
    idle(1);
    addr_in = a ^ AW'(2);
    for (int i = 1; i < width; i++) begin
      if (i == width / 2 && oe_blip) oe_n = 1'b0;
      else oe_n = 1'b1;
      if (i == width - 1) dq_in = d;
      idle(1);
    end
    oe_n = 1'b1;
    if (ce_rises_first) ce_n = 1'b1; else we_n = 1'b1;
    dq_in   = d ^ 8'h3C;
    addr_in = a ^ AW'(4);
    idle(2);
    ce_n = 1'b1;
    we_n = 1'b1;
    idle(8);
    check(exp_q.size() == 0, req, "scoreboard drained", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    int timeout = 0;
    while (timeout < 100000) begin
      @(posedge clk);
      timeout++;
    end
    check(1'b0, "R1", "watchdog expired", 32'(timeout), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R9: reset state
    check(wr_valid == 1'b0, "R9", "wr_valid in reset", 32'(wr_valid), 32'h0);
    check(dq_oe == 1'b0, "R9", "dq_oe in reset", 32'(dq_oe), 32'h0);
    rst_n = 1'b1;
    idle(4);
    check(wr_addr == '0, "R9", "wr_addr after reset", 32'(wr_addr), 32'h0);
    check(wr_data == '0, "R9", "wr_data after reset", 32'(wr_data), 32'h0);
    check(dq_out == '0, "R9", "dq_out after reset", 32'(dq_out), 32'h0);
    check(rd_start == 1'b0, "R9", "rd_start after reset", 32'(rd_start), 32'h0);

    // R2/R3 edge orderings
    bus_write(19'h05555, 8'hAA, 8, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    bus_write(19'h02AAA, 8'h55, 8, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    bus_write(19'h12345, 8'hA0, 6, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
    bus_write(19'h7FFFF, 8'h10, 6, 1'b1, 1'b1, 1'b0, 1'b1, "R3");

    // R4: width filter around MINW
    bus_write(19'h00100, 8'h11, MINW - 1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    bus_write(19'h00200, 8'h22, 1, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    bus_write(19'h00300, 8'h33, MINW, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
    bus_write(19'h00400, 8'h44, MINW + 1, 1'b1, 1'b0, 1'b0, 1'b1, "R4");

    // R5: OE low during the strobe inhibits
    bus_write(19'h00500, 8'h55, 8, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    bus_write(19'h00600, 8'h66, 6, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
    bus_write(19'h00700, 8'h77, 6, 1'b0, 1'b0, 1'b0, 1'b1, "R5");

    // R6: write-strobe pulses with chip-select high
    for (int k = 0; k < 3; k++) begin
      addr_in = AW'(k * 3 + 1);
      dq_in = 8'hE0 + DW'(k);
      we_n = 1'b0;
      idle(8);
      we_n = 1'b1;
      idle(3);
    end
    idle(6);
    check(wr_addr == 19'h00700, "R6", "wr_addr unchanged", 32'(wr_addr), 32'h700);
    check(exp_q.size() == 0, "R6", "no pending events", 32'(exp_q.size()), 32'h0);

    // R7/R8: read gating
    rd_pulses = 0;
    rd_data = 8'h5A;
    ce_n = 1'b0; oe_n = 1'b0;
    idle(4);
    check(dq_oe == 1'b1, "R7", "dq_oe in read window", 32'(dq_oe), 32'h1);
    check(dq_out == 8'h5A, "R7", "dq_out in read window", 32'(dq_out), 32'h5A);
    rd_data = 8'hC3;
    idle(1);
    check(dq_out == 8'hC3, "R7", "dq_out follows rd_data", 32'(dq_out), 32'hC3);
    ce_n = 1'b1;
    idle(4);
    check(dq_oe == 1'b0, "R7", "dq_oe with CE high", 32'(dq_oe), 32'h0);
    check(dq_out == '0, "R7", "dq_out with CE high", 32'(dq_out), 32'h0);
    ce_n = 1'b0; oe_n = 1'b1;
    idle(4);
    check(dq_oe == 1'b0, "R7", "dq_oe with OE high", 32'(dq_oe), 32'h0);
    oe_n = 1'b0;
    idle(5);
    oe_n = 1'b1; ce_n = 1'b1;
    idle(4);
    check(rd_pulses == 2, "R8", "read window pulses", 32'(rd_pulses), 32'h2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule